// File: doc/BRIEF.md
# Multi-Port Packet Transmit Link Scheduler

This block is the link-layer end of a byte-wide packet transmit bus that feeds four PHY ports. Each PHY port has its own active-high availability line saying whether it can take more packet data. On the upstream side, each port has a show-ahead FIFO that presents one byte together with an end-of-packet marker and a bad-packet marker. The block pops a byte from the FIFO when it sends it. Toward the PHYs, the block drives a transmit enable, a port address, a data byte and start, end and error strobes. All of these are registered, and exactly one byte moves per clock.

Packets bound for different ports are interleaved at byte granularity. If the port being served drops its availability line, the block switches away on the following edge and keeps a per-port in-packet flag. When that port is picked again, its packet continues from the next byte and the start strobe is not repeated. After an end-of-packet byte, the block moves to the next eligible port in round-robin order. Availability is sampled into a register, so a byte is only launched to a port whose line was high at the previous edge.

Top module: `pktx_link_sched`

## Requirements
- R1: Synchronous active-high reset clears all transmit outputs to zero, including the address. While reset is held no FIFO pop is issued, and the first decision after reset sees every port as unavailable.
- R2: At most one `src_pop_o` bit is high per cycle, and only for a port whose `src_valid_i` is high. The byte popped at an edge appears on `tx_data_o` in the next cycle, with `tx_en_o` high and `tx_addr_o` equal to that port number.
- R3: A byte is launched at edge E to port p only if `avail_i[p]` was high at edge E-1. If the served port's line is low at edge N, the output from edge N+1 on carries another port or is idle.
- R4: A byte is launched to the same port as the previous cycle's byte whenever all three of these hold: the previous byte was not an end of packet, that port was available at the previous edge, and its FIFO is non-empty. In that case no round-robin choice is made.
- R5: `tx_sop_o` is high only on the first byte of a packet. A packet that resumes after a suspension continues without `tx_sop_o`.
- R6: `tx_eop_o` is high with the last byte of a packet. The next byte sent to that same port starts a new packet.
- R7: `tx_err_o` is high only together with `tx_eop_o`, and only when the source marked that last byte bad with `src_err_i`.
- R8: When no continuation applies, the next port is chosen among ports that are both available and holding data. The search starts at port index (last served + 1) mod 4 and wraps around, so the last served port has the lowest priority. After reset the last served index is 0.
- R9: When no port is eligible, `tx_en_o` is low, `tx_data_o`, `tx_sop_o`, `tx_eop_o` and `tx_err_o` are zero, and `tx_addr_o` holds its last value.
- R10: The bytes of each port leave in FIFO order, with no byte skipped or repeated across any number of suspensions and resumptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_i | input | N | Per-port availability, bit p for port p |
| src_valid_i | input | N | Per-port FIFO non-empty |
| src_data_i | input | N*DW | Head byte of each FIFO, port p at bits [p*DW +: DW] |
| src_eop_i | input | N | Head byte is the last of its packet |
| src_err_i | input | N | Head packet is bad (meaningful with end marker) |
| src_pop_o | output | N | Pop the head byte of port p's FIFO at this edge |
| tx_en_o | output | 1 | Transmit enable |
| tx_addr_o | output | IW | Port number of the byte on the bus |
| tx_data_o | output | DW | Data byte |
| tx_sop_o | output | 1 | First byte of a packet |
| tx_eop_o | output | 1 | Last byte of a packet |
| tx_err_o | output | 1 | Packet is bad, with end of packet |

## Verification
Assertions check on every cycle the properties that hold locally:
- single, valid pops and the pop-to-bus one-cycle relation;
- the rule that a byte never goes to a port that was unavailable two edges back;
- error only with end of packet, and quiet outputs when idle;
- start of packet on a same-port byte that follows an end of packet.

Round-robin order, the suppression of the start strobe on resumed packets, and byte order across suspensions depend on history across many cycles. Only the bench's reference model shows these, as it tracks every FIFO and port flag through directed and pseudo-random availability patterns.

// File: rtl/pktx_pkg.sv
package pktx_pkg;

  // Flags that travel with each launched byte.
  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
  } tx_flags_t;

  // Number of bits needed to index n ports (at least one).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pktx_rr_pick.sv
// Round-robin pick: first requester after 'last', wrapping, 'last' lowest.
module pktx_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          vld,
  output logic [IW-1:0] idx
);

  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = 1; i <= N; i++) begin
      int j;
      j = (int'(last) + i) % N;
      if (!vld && req[j]) begin
        vld = 1'b1;
        idx = IW'(j);
      end
    end
  end

endmodule

// File: rtl/pktx_port_state.sv
// Per-port in-packet flags: set after a non-final byte, cleared by end of packet.
module pktx_port_state #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [IW-1:0] launch_idx,
  input  logic          launch_eop,
  output logic [N-1:0]  inpkt
);

  for (genvar p = 0; p < N; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        inpkt[p] <= 1'b0;
      end else if (launch && (launch_idx == IW'(p))) begin
        inpkt[p] <= ~launch_eop;
      end
    end

    // R5: a resumed packet keeps its flag while the port is not served
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !(launch && (launch_idx == IW'(p))) |=> $stable(inpkt[p]));
  end

endmodule

// File: rtl/pktx_link_sched.sv
module pktx_link_sched
  import pktx_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = idx_bits(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    avail_i,
  input  logic [N-1:0]    src_valid_i,
  input  logic [N*DW-1:0] src_data_i,
  input  logic [N-1:0]    src_eop_i,
  input  logic [N-1:0]    src_err_i,
  output logic [N-1:0]    src_pop_o,
  output logic            tx_en_o,
  output logic [IW-1:0]   tx_addr_o,
  output logic [DW-1:0]   tx_data_o,
  output logic            tx_sop_o,
  output logic            tx_eop_o,
  output logic            tx_err_o
);

  logic [N-1:0]  avail_q;
  logic [N-1:0]  elig;
  logic [N-1:0]  inpkt;
  logic          hold;
  logic          rr_vld;
  logic [IW-1:0] rr_idx;
  logic          go;
  logic [IW-1:0] sel;
  tx_flags_t     nxt_flags;

  // Availability sampled once; decisions use the previous edge's value.
  always_ff @(posedge clk) begin
    if (rst) avail_q <= '0;
    else     avail_q <= avail_i;
  end

  assign elig = avail_q & src_valid_i;

  pktx_rr_pick #(.N(N), .IW(IW)) rr_i (
    .req  (elig),
    .last (tx_addr_o),
    .vld  (rr_vld),
    .idx  (rr_idx)
  );

  pktx_port_state #(.N(N), .IW(IW)) st_i (
    .clk        (clk),
    .rst        (rst),
    .launch     (go),
    .launch_idx (sel),
    .launch_eop (src_eop_i[sel]),
    .inpkt      (inpkt)
  );

  always_comb begin
    hold          = tx_en_o && !tx_eop_o && elig[tx_addr_o];
    go            = hold || rr_vld;
    sel           = hold ? tx_addr_o : rr_idx;
    nxt_flags.sop = !inpkt[sel];
    nxt_flags.eop = src_eop_i[sel];
    nxt_flags.err = src_eop_i[sel] && src_err_i[sel];
    src_pop_o     = '0;
    if (go) src_pop_o[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_o   <= 1'b0;
      tx_addr_o <= '0;
      tx_data_o <= '0;
      tx_sop_o  <= 1'b0;
      tx_eop_o  <= 1'b0;
      tx_err_o  <= 1'b0;
    end else if (go) begin
      tx_en_o   <= 1'b1;
      tx_addr_o <= sel;
      tx_data_o <= src_data_i[sel*DW +: DW];
      tx_sop_o  <= nxt_flags.sop;
      tx_eop_o  <= nxt_flags.eop;
      tx_err_o  <= nxt_flags.err;
    end else begin
      tx_en_o   <= 1'b0;
      tx_data_o <= '0;
      tx_sop_o  <= 1'b0;
      tx_eop_o  <= 1'b0;
      tx_err_o  <= 1'b0;
    end
  end

  // R2: single pop, never from an empty FIFO
  p_pop_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_pop_o) && ((src_pop_o & ~src_valid_i) == '0));

  for (genvar p = 0; p < N; p++) begin : g_chk
    // R2: popped byte appears on the bus next cycle
    p_pop_to_bus_r2: assert property (@(posedge clk) disable iff (rst)
      src_pop_o[p] |=> tx_en_o && (tx_addr_o == IW'(p)) &&
                       (tx_data_o == $past(src_data_i[p*DW +: DW])));
    // R3: bus byte to port p needs p available two edges back
    p_avail_r3: assert property (@(posedge clk) disable iff (rst)
      (tx_en_o && (tx_addr_o == IW'(p))) |-> $past(avail_i[p], 2));
  end

  // R7: error only with end of packet
  p_err_eop_r7: assert property (@(posedge clk) disable iff (rst)
    tx_err_o |-> (tx_eop_o && tx_en_o));

  // R9: idle bus is quiet
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !tx_en_o |-> ((tx_data_o == '0) && !tx_sop_o && !tx_eop_o && !tx_err_o));

  // R6: same port right after its end of packet starts a new packet
  p_sop_after_eop_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_en_o && $past(tx_en_o) && $past(tx_eop_o) &&
     (tx_addr_o == $past(tx_addr_o))) |-> tx_sop_o);

endmodule

// File: tb/pktx_link_sched_tb_top.sv
`timescale 1ns/1ps
module pktx_link_sched_tb_top;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    avail = '0;
  logic [N-1:0]    sv = '0;
  logic [N*DW-1:0] sd = '0;
  logic [N-1:0]    se = '0;
  logic [N-1:0]    serr = '0;
  logic [N-1:0]    src_pop_o;
  logic            tx_en_o;
  logic [IW-1:0]   tx_addr_o;
  logic [DW-1:0]   tx_data_o;
  logic            tx_sop_o, tx_eop_o, tx_err_o;

  always #2.5 clk = ~clk;

  pktx_link_sched #(.N(N), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .avail_i(avail), .src_valid_i(sv),
    .src_data_i(sd), .src_eop_i(se), .src_err_i(serr), .src_pop_o(src_pop_o),
    .tx_en_o(tx_en_o), .tx_addr_o(tx_addr_o), .tx_data_o(tx_data_o),
    .tx_sop_o(tx_sop_o), .tx_eop_o(tx_eop_o), .tx_err_o(tx_err_o)
  );

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int q [N][$];        // bit 9 err, bit 8 last, bits 7:0 data
  bit [N-1:0] mask = '1;

  // reference model state
  bit       m_en = 0;
  int       m_addr = 0;
  int       m_data = 0;
  bit       m_sop = 0, m_eop = 0, m_err = 0;
  bit [N-1:0] m_inpkt = '0;
  bit [N-1:0] m_availq = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_pkt(input int p, input int len, input bit bad);
    for (int i = 0; i < len; i++) begin
      int e;
      e = (seq & 255) | ((i == len - 1) ? 256 : 0) | (bad ? 512 : 0);
      seq++;
      q[p].push_back(e);
    end
  endtask

  task automatic step(input logic [N-1:0] av);
    bit [N-1:0] elig;
    bit [N-1:0] exp_pop;
    bit go;
    int sel;
    @(negedge clk);
    chk(tx_en_o == m_en, "R3 R4 en", int'(tx_en_o), int'(m_en));
    chk(tx_addr_o == IW'(m_addr), "R8 R4 addr", int'(tx_addr_o), m_addr);
    chk(tx_data_o == DW'(m_data), m_en ? "R10 data" : "R9 data", int'(tx_data_o), m_data);
    chk(tx_sop_o == m_sop, "R5 sop", int'(tx_sop_o), int'(m_sop));
    chk(tx_eop_o == m_eop, "R6 eop", int'(tx_eop_o), int'(m_eop));
    chk(tx_err_o == m_err, "R7 err", int'(tx_err_o), int'(m_err));
    avail = av;
    for (int p = 0; p < N; p++) begin
      if (mask[p] && q[p].size() > 0) begin
        sv[p] = 1'b1;
        sd[p*DW +: DW] = DW'(q[p][0] & 255);
        se[p] = q[p][0][8];
        serr[p] = q[p][0][9];
      end else begin
        sv[p] = 1'b0;
        sd[p*DW +: DW] = '0;
        se[p] = 1'b0;
        serr[p] = 1'b0;
      end
    end
    #1;
    elig = m_availq & sv;
    go = 0;
    sel = 0;
    if (m_en && !m_eop && elig[m_addr]) begin
      go = 1;
      sel = m_addr;
    end else begin
      for (int i = 1; i <= N; i++) begin
        int j;
        j = (m_addr + i) % N;
        if (!go && elig[j]) begin
          go = 1;
          sel = j;
        end
      end
    end
    exp_pop = '0;
    if (go) exp_pop[sel] = 1'b1;
    chk(src_pop_o == exp_pop, "R2 pop", int'(src_pop_o), int'(exp_pop));
    if (go) begin
      int e;
      e = q[sel].pop_front();
      m_en = 1;
      m_addr = sel;
      m_data = e & 255;
      m_sop = !m_inpkt[sel];
      m_eop = e[8];
      m_err = e[8] & e[9];
      m_inpkt[sel] = !e[8];
    end else begin
      m_en = 0;
      m_data = 0;
      m_sop = 0;
      m_eop = 0;
      m_err = 0;
    end
    m_availq = av;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!tx_en_o && tx_addr_o == 0 && tx_data_o == 0, "R1 reset outputs",
        int'(tx_en_o), 0);
    chk(!tx_sop_o && !tx_eop_o && !tx_err_o && src_pop_o == 0, "R1 reset strobes",
        int'(src_pop_o), 0);
    rst = 1'b0;

    // single packet on port 0 (R8: port 0 is last in order after reset)
    push_pkt(0, 5, 0);
    repeat (8) step(4'hF);

    // all ports, packet-by-packet round robin (R8, R6)
    for (int p = 0; p < N; p++) push_pkt(p, 3 + p, 0);
    for (int p = 0; p < N; p++) push_pkt(p, 2, 0);
    repeat (34) step(4'hF);

    // suspension and resume (R3, R5, R10)
    push_pkt(1, 12, 0);
    push_pkt(2, 6, 0);
    repeat (4) step(4'hF);
    repeat (6) step(4'b1101);
    repeat (2) step(4'b1001);
    repeat (20) step(4'hF);

    // bad packets, including a one-byte one (R7)
    push_pkt(3, 4, 1);
    push_pkt(0, 1, 1);
    push_pkt(0, 3, 0);
    repeat (12) step(4'hF);

    // source underrun mid packet (R4, R9)
    push_pkt(2, 8, 0);
    push_pkt(0, 4, 0);
    repeat (3) step(4'hF);
    mask[2] = 1'b0;
    repeat (6) step(4'hF);
    mask[2] = 1'b1;
    repeat (10) step(4'hF);

    // pseudo-random availability and traffic
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h5) push_pkt(int'(lfsr[5:4]), 1 + int'(lfsr[9:6]) % 9, lfsr[11]);
      mask = lfsr[15:12] | 4'b0101;
      step(lfsr[7:4] | lfsr[11:8]);
    end
    mask = '1;
    repeat (300) step(4'hF);
    for (int p = 0; p < N; p++)
      chk(q[p].size() == 0, "R10 drained", q[p].size(), 0);
    step(4'hF);
    chk(!tx_en_o, "R9 idle after drain", int'(tx_en_o), 0);
    finish_run();
  end

endmodule